// File: doc/BRIEF.md
# PS/2 Receive Channel with Configurable Frame Checks

This block receives bytes that a PS/2 device sends to the host. It watches the PS/2 clock and data lines and counts falling edges of the clock. On each falling edge it samples the data line. A frame is a low start bit, eight data bits with the least significant bit first, a parity bit and a stop bit. When a frame completes, the byte goes into a receive register and a ready flag is raised. The ready flag stays set until the host pulses a read strobe. Each received byte also carries a parity-error flag and a framing-error flag.

A seven-bit control word, written through a write-enable port, sets up the channel:
- It enables or disables the channel.
- It picks the expected parity: odd, even or not checked.
- It picks the expected stop level: high, low or not checked.
- It switches a glitch filter on the incoming clock line on or off.
- It holds an inhibit bit. A rising edge of this bit pulls the PS/2 clock low for 100 µs through an open-drain pull output. The pulse is timed from the system clock frequency.

The channel also pulls the clock low on its own while it is enabled and holds an unread byte. This tells the device to wait. The two low-drive sources are ORed together.

Top module: `ps2_rx_chan`

## Requirements
- R1: With control bit 7 set, a change on the PS/2 clock line is accepted only after it has held for FILT_LEN consecutive system clocks, so shorter pulses are ignored. With bit 7 clear, the synchronised raw level is used.
- R2: Each falling edge of the accepted clock samples the data line. A frame is bit0 = start (low), bits 1..8 = data with the LSB first, bit 9 = parity, bit 10 = stop. When the frame completes, the byte appears on rx_byte_o and rx_ready_o goes to 1.
- R3: A 0-to-1 change of control bit 6 asserts ps2_clk_pull_o for exactly CLK_HZ/1e6*PULSE_US system clocks. A 1-to-0 change starts no pulse.
- R4: A new rising edge of control bit 6 while a pulse is running restarts the full pulse length.
- R5: ps2_clk_pull_o is the OR of the inhibit pulse and an internal hold-off term. The hold-off term is active while the channel is enabled and rx_ready_o is 1.
- R6: Control bits [3:2] set the parity check. 00 expects odd parity over the data and parity bits, 01 expects even parity, and 10 or 11 never report a parity error. A mismatch sets par_err_o together with the byte.
- R7: Control bits [5:4] set the stop check. 00 expects a high stop bit, 01 expects a low stop bit, and 10 or 11 never report a framing error. A mismatch sets frm_err_o together with the byte.
- R8: The control word resets to all zeros, so the channel starts disabled. While control bit 1 is 0, no frame is received and rx_ready_o stays 0.
- R9: If control bit 1 is cleared mid-frame before the parity-bit falling edge, the partial byte is dropped and rx_ready_o stays 0.
- R10: If control bit 1 is cleared after the parity-bit falling edge but before the stop edge, the byte is stored, rx_ready_o goes to 1, and par_err_o and frm_err_o are 0.
- R11: A pulse on rx_rd clears rx_ready_o.
- R12: If the data line is high at the first falling edge, that edge does not start a frame, and the next low start bit is decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 7 | Control word bits [7:1]: 7 filter, 6 inhibit, 5:4 stop mode, 3:2 parity mode, 1 enable |
| rx_rd | input | 1 | Read strobe; clears the ready flag |
| ps2_clk_i | input | 1 | PS/2 clock line level |
| ps2_dat_i | input | 1 | PS/2 data line level |
| ps2_clk_pull_o | output | 1 | 1 = pull the PS/2 clock line low (drives an open-drain pad) |
| rx_byte_o | output | 8 | Last received byte |
| rx_ready_o | output | 1 | Unread byte present |
| par_err_o | output | 1 | Parity error on the last byte |
| frm_err_o | output | 1 | Stop-bit error on the last byte |

## Verification
The bench builds the block with CLK_HZ = 1,000,000 and the default FILT_LEN = 4. This makes the inhibit pulse 100 cycles long, so its exact length can be counted cycle by cycle. It also makes a restart part-way through the pulse easy to observe in a short run. With a four-cycle filter, a two-cycle clock glitch injected into a data bit's high phase must leave the byte unchanged. The stimulus covers:
- every code of both mode fields;
- both the discard case and the keep case when the channel is disabled mid-frame;
- a false start bit.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

  typedef enum logic [1:0] {
    PAR_ODD  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_SKIP = 2'b10,
    PAR_RSV  = 2'b11
  } par_mode_e;

  typedef enum logic [1:0] {
    STP_HIGH = 2'b00,
    STP_LOW  = 2'b01,
    STP_SKIP = 2'b10,
    STP_RSV  = 2'b11
  } stop_mode_e;

  // control word, bits [7:1]
  typedef struct packed {
    logic       filt_en;
    logic       inhibit;
    stop_mode_e stop;
    par_mode_e  par;
    logic       en;
  } ctl_t;

endpackage

// File: rtl/ps2_clk_filter.sv
module ps2_clk_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic filt_en,
  input  logic line_i,
  output logic fall_o
);
  localparam int RW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(FILT_LEN - 1);

  logic s1_q, s2_q, filt_q, prev_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      prev_q <= 1'b1;
      run_q  <= '0;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      prev_q <= filt_q;
      if (!filt_en) begin
        filt_q <= s2_q;
        run_q  <= '0;
      end else if (s2_q == filt_q) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        filt_q <= s2_q;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign fall_o = prev_q & ~filt_q;

  // R1: with the filter on, an accepted level must match the synchroniser output of the cycle before
  assert_filter_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (filt_en && $past(filt_en) && (filt_q != $past(filt_q))) |-> (filt_q == $past(s2_q)));

endmodule

// File: rtl/ps2_inhibit_pulse.sv
module ps2_inhibit_pulse #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int PULSE_US = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic inhibit_i,
  output logic active_o
);
  localparam int PULSE_CYC = (CLK_HZ / 1_000_000) * PULSE_US;
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC);

  logic          inh_prev_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise = inhibit_i & ~inh_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      inh_prev_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      inh_prev_q <= inhibit_i;
      if (rise)
        cnt_q <= PULSE_LD;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = (cnt_q != '0);

  // R3: the remaining count never exceeds the pulse length
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= PULSE_LD);

  // R3: a falling edge of the inhibit input never starts a pulse from idle
  assert_no_fall_start_R3: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !inhibit_i) |=> !active_o);

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       fall,
  input  logic       din,
  input  par_mode_e  par_mode,
  input  stop_mode_e stop_mode,
  output logic       done_o,
  output logic [7:0] byte_o,
  output logic       perr_o,
  output logic       ferr_o
);
  logic       busy_q;
  logic [3:0] bits_q;
  logic [7:0] sh_q;
  logic       par_q;
  logic       odd_ok;
  logic       perr_n, ferr_n;

  assign odd_ok = (^sh_q) ^ par_q;

  always_comb begin
    unique case (par_mode)
      PAR_ODD:  perr_n = ~odd_ok;
      PAR_EVEN: perr_n = odd_ok;
      default:  perr_n = 1'b0;
    endcase
    unique case (stop_mode)
      STP_HIGH: ferr_n = ~din;
      STP_LOW:  ferr_n = din;
      default:  ferr_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      bits_q <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      done_o <= 1'b0;
      byte_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en) begin
        if (busy_q && bits_q == 4'd10) begin
          done_o <= 1'b1;
          byte_o <= sh_q;
          perr_o <= 1'b0;
          ferr_o <= 1'b0;
        end
        busy_q <= 1'b0;
        bits_q <= '0;
      end else if (fall) begin
        if (!busy_q) begin
          if (!din) begin
            busy_q <= 1'b1;
            bits_q <= 4'd1;
          end
        end else if (bits_q < 4'd9) begin
          sh_q   <= {din, sh_q[7:1]};
          bits_q <= bits_q + 4'd1;
        end else if (bits_q == 4'd9) begin
          par_q  <= din;
          bits_q <= 4'd10;
        end else begin
          done_o <= 1'b1;
          byte_o <= sh_q;
          perr_o <= perr_n;
          ferr_o <= ferr_n;
          busy_q <= 1'b0;
          bits_q <= '0;
        end
      end
    end
  end

  // R9: disabling before the parity edge never delivers a byte
  assert_discard_R9: assert property (@(posedge clk) disable iff (rst)
    (!en && busy_q && bits_q < 4'd10) |=> !done_o);

  // R10: disabling after the parity edge delivers the byte with no parity error
  assert_late_keep_R10: assert property (@(posedge clk) disable iff (rst)
    (!en && busy_q && bits_q == 4'd10) |=> (done_o && !perr_o && !ferr_o));

endmodule

// File: rtl/ps2_rx_chan.sv
module ps2_rx_chan
  import ps2_rx_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int PULSE_US = 100,
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic [7:1] ctl_wdata,
  input  logic       rx_rd,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_pull_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_ready_o,
  output logic       par_err_o,
  output logic       frm_err_o
);
  ctl_t       ctl_q;
  logic       d1_q, d2_q;
  logic       fall;
  logic       pulse_act;
  logic       done;
  logic [7:0] f_byte;
  logic       f_perr, f_ferr;

  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= '0;
    else if (ctl_we)
      ctl_q <= ctl_t'(ctl_wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d1_q <= 1'b1;
      d2_q <= 1'b1;
    end else begin
      d1_q <= ps2_dat_i;
      d2_q <= d1_q;
    end
  end

  ps2_clk_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .filt_en (ctl_q.filt_en),
    .line_i  (ps2_clk_i),
    .fall_o  (fall)
  );

  ps2_inhibit_pulse #(.CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US)) u_pulse (
    .clk       (clk),
    .rst       (rst),
    .inhibit_i (ctl_q.inhibit),
    .active_o  (pulse_act)
  );

  ps2_frame_rx u_frame (
    .clk       (clk),
    .rst       (rst),
    .en        (ctl_q.en),
    .fall      (fall),
    .din       (d2_q),
    .par_mode  (ctl_q.par),
    .stop_mode (ctl_q.stop),
    .done_o    (done),
    .byte_o    (f_byte),
    .perr_o    (f_perr),
    .ferr_o    (f_ferr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte_o      <= '0;
      rx_ready_o     <= 1'b0;
      par_err_o      <= 1'b0;
      frm_err_o      <= 1'b0;
      ps2_clk_pull_o <= 1'b0;
    end else begin
      if (done) begin
        rx_byte_o  <= f_byte;
        rx_ready_o <= 1'b1;
        par_err_o  <= f_perr;
        frm_err_o  <= f_ferr;
      end else if (rx_rd) begin
        rx_ready_o <= 1'b0;
      end
      ps2_clk_pull_o <= pulse_act | (ctl_q.en & rx_ready_o);
    end
  end

  // R5: an enabled channel holding an unread byte pulls the clock low
  assert_hold_pull_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.en && rx_ready_o) |=> ps2_clk_pull_o);

  // R11: a read with no completing frame clears the ready flag
  assert_read_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !done) |=> !rx_ready_o);

  // R8: a disabled channel never raises the ready flag
  assert_idle_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.en && !rx_ready_o && !done) |=> !rx_ready_o);

endmodule

// File: tb/ps2_rx_chan_tb.sv
module ps2_rx_chan_tb_top;
  localparam int CLK_HZ = 1_000_000;
  localparam int PCYC   = 100;
  localparam int NVEC   = 12;
  localparam int LIMIT  = 100_000;

  // [31:24] ctl {bit7..bit1, pad 0}, [23:16] data, 15 parity sent, 14 stop sent, 13 exp perr, 12 exp ferr
  localparam logic [31:0] VEC [NVEC] = '{
    32'h825A_C000, 32'h825A_6000, 32'h8601_C000, 32'h8601_6000,
    32'h8AFF_4000, 32'h8E3C_C000, 32'h9280_0000, 32'h9280_5000,
    32'hA200_8000, 32'hB2C3_8000, 32'h0296_C000, 32'h8211_9000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [7:1] ctl_wdata = '0;
  logic rx_rd = 1'b0;
  logic ps2_clk = 1'b1;
  logic ps2_dat = 1'b1;
  logic pull;
  logic [7:0] rx_byte;
  logic rx_ready, par_err, frm_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  ps2_rx_chan #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rx_rd(rx_rd), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .ps2_clk_pull_o(pull), .rx_byte_o(rx_byte), .rx_ready_o(rx_ready),
    .par_err_o(par_err), .frm_err_o(frm_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v[7:1];
    @(posedge clk); @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rx_rd = 1'b1;
    @(posedge clk); @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [10:0] frame(input logic [7:0] d, input logic p, input logic s);
    return {s, p, d, 1'b0};
  endfunction

  // send the first n bits of fr; optional two-cycle clock glitch in the high phase of bit 3
  task automatic send(input logic [10:0] fr, input int n, input bit glitch);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ps2_dat = fr[i];
      idle(6);
      if (glitch && i == 3) begin
        ps2_clk = 1'b0; idle(2); ps2_clk = 1'b1;
      end
      idle(4);
      ps2_clk = 1'b0;
      idle(12);
      ps2_clk = 1'b1;
    end
    idle(6);
    ps2_dat = 1'b1;
  endtask

  int cnt;

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    // R8: reset state
    chk("R8 ready after reset", rx_ready, 0);
    chk("R8 byte after reset", rx_byte, 0);
    chk("R5 pull after reset", pull, 0);
    // R8: disabled channel ignores a frame
    send(frame(8'h33, 1'b1, 1'b1), 11, 0);
    idle(20);
    chk("R8 no ready while disabled", rx_ready, 0);

    // table: R2, R6, R7, R1 (bypass), R5, R11
    for (int v = 0; v < NVEC; v++) begin
      wr(VEC[v][31:24]);
      send(frame(VEC[v][23:16], VEC[v][15], VEC[v][14]), 11, 0);
      idle(20);
      chk("R2 ready", rx_ready, 1);
      chk("R2 byte", rx_byte, VEC[v][23:16]);
      chk("R6 parity flag", par_err, VEC[v][13]);
      chk("R7 stop flag", frm_err, VEC[v][12]);
      chk("R5 hold-off pull", pull, 1);
      rd();
      chk("R11 ready cleared", rx_ready, 0);
      idle(1);
      chk("R5 pull released", pull, 0);
    end

    // R1: glitch rejected with the filter on
    wr(8'h82);
    send(frame(8'hA5, 1'b1, 1'b1), 11, 1);
    idle(20);
    chk("R1 glitch ready", rx_ready, 1);
    chk("R1 glitch byte", rx_byte, 8'hA5);
    chk("R1 glitch parity", par_err, 0);
    rd();

    // R12: high level at first falling edge is not a start bit
    send(11'h7FF, 1, 0);
    idle(10);
    send(frame(8'h6C, 1'b1, 1'b1), 11, 0);
    idle(20);
    chk("R12 byte after false start", rx_byte, 8'h6C);
    chk("R12 stop flag", frm_err, 0);
    rd();

    // R9: disable before parity edge drops the byte
    send(frame(8'hE7, 1'b1, 1'b1), 6, 0);
    wr(8'h80);
    idle(20);
    chk("R9 discarded", rx_ready, 0);
    wr(8'h82);
    send(frame(8'h42, 1'b1, 1'b1), 11, 0);
    idle(20);
    chk("R9 next frame byte", rx_byte, 8'h42);
    rd();

    // R10: disable after parity edge keeps the byte, wrong parity not flagged
    send(frame(8'hA5, 1'b0, 1'b1), 10, 0);
    idle(10);
    wr(8'h80);
    idle(5);
    chk("R10 ready kept", rx_ready, 1);
    chk("R10 byte kept", rx_byte, 8'hA5);
    chk("R10 parity flag clear", par_err, 0);
    rd();
    chk("R10 cleared by read", rx_ready, 0);

    // R3: fresh inhibit pulse length
    wr(8'h40);
    cnt = 0;
    for (int k = 0; k < 2 * PCYC + 10; k++) begin
      @(negedge clk); if (pull) cnt++;
    end
    chk("R3 pulse length", cnt, PCYC);
    wr(8'h00);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); if (pull) cnt++;
    end
    chk("R3 no pulse on fall", cnt, 0);

    // R4: restart during an active pulse
    wr(8'h40);
    idle(30);
    wr(8'h00);
    wr(8'h40);
    cnt = 0;
    for (int k = 0; k < 2 * PCYC + 10; k++) begin
      @(negedge clk); if (pull) cnt++;
    end
    chk("R4 restarted pulse", cnt, PCYC + 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule